// File: doc/BRIEF.md
# Link Alarm Interrupt Aggregator with General-Purpose Pins

This block collects many status sources into one active-high interrupt line. It handles four kinds of source. Internal event pulses are latched until software reads them. Optical-lane status pins and a group of alarm flags are shown as live levels. General-purpose pins can each serve as an input or as an output. A mode pin tells the block whether the module is an optical-lane part. Only then do the optical pins and the alarm flags count as sources.

Software reaches the block through a simple register port with a one-cycle read latency. Three status registers hold the latched and live conditions. Three matching enable registers choose which of those conditions may drive the interrupt. More registers hold the per-alarm enables and the pin direction, output value and trigger level of each general-purpose pin. A last register returns the sampled level of every general-purpose pin.

Register addresses (4-bit): 0 event status, 1 link status, 2 pin-trigger status, 3 event enable, 4 link enable, 5 pin-trigger enable, 6 alarm enable, 7 pin direction, 8 pin output value, 9 pin trigger level, 10 pin level. Addresses 11 to 15 are unmapped.

The reset input is asynchronous and active low. Its release is synchronised inside the block through two flops. The registers therefore start to update on the third rising edge after the release.

Top module: `link_irq_hub`

## Requirements
- R1: While reset is active and right after it, every register reads 0, `irq_o` is 0, and `gpio_oe` and `gpio_out` are 0.
- R2: Bit i of the event status register (address 0) is set at any clock edge where `evt_i[i]` is 1. It stays set until address 0 is read.
- R3: A read of address 0 returns the current event bits and clears them at the same edge. A bit whose `evt_i` input is 1 during that read stays set.
- R4: Bits [N_OPT-1:0] of the link status register (address 1) take the levels of `opt_i` one edge after they are sampled, but only while `mode_opt` is 1. While `mode_opt` is 0 they read 0.
- R5: Bit 15 of address 1 is 1 when `mode_opt` is 1 and at least one alarm bit `alm_i[j]` is 1 with its enable bit j set in address 6. Otherwise bit 15 is 0.
- R6: Bit i of the pin-trigger status register (address 2) is 1 when pin i is an input (direction bit 0 in address 7) and its level equals trigger bit i in address 9, where 1 means high and 0 means low. Output pins never set it.
- R7: `gpio_oe` equals the direction register (address 7, where 1 means output) and `gpio_out` equals the output-value register (address 8).
- R8: Address 10 returns the sampled level of every general-purpose pin, whatever the pin's direction.
- R9: `irq_o` is the OR of (status AND enable) over the three status/enable register pairs, with event at 0/3, link at 1/4 and pin trigger at 2/5. It falls once no enabled status bit is set.
- R10: `reg_rdata` shows the addressed register one cycle after `reg_re`. Writes to the read-only addresses 0, 1, 2 and 10 have no effect, and reads of addresses 11 to 15 return 0.
- R11: A write takes effect at its clock edge. The written control value appears on the pins and in read-back in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_re` |
| mode_opt | input | 1 | 1 = optical-lane mode; enables optical pins and alarms |
| evt_i | input | N_INT | Internal event pulses |
| opt_i | input | N_OPT | Optical interface status pins |
| alm_i | input | N_ALM | Alarm flags |
| gpio_in | input | N_GPIO | Sampled general-purpose pin levels |
| gpio_out | output | N_GPIO | General-purpose output values |
| gpio_oe | output | N_GPIO | General-purpose output enables |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
The stimulus tests the event path with three patterns. A single pulse read back once shows that events latch. A second read tells a sticky bit apart from a bit that is never cleared. A pulse held high across the read tells whether a new event wins over the clear.

Optical pins and alarms are driven with `mode_opt` both 0 and 1. The alarm enables are set to match and then to miss the active flags, which separates the masking by mode from the masking by enable.

General-purpose pins are driven with some pins as outputs and some as inputs. Those inputs use high and low trigger levels, with the pin levels first matching and then opposing them. This separates the direction, trigger-level and output paths.

Writes to read-only addresses and reads of unmapped addresses check that the register port decodes its addresses.

// File: rtl/lah_pkg.sv
package lah_pkg;
  localparam int DW = 16;
  localparam int AW = 4;

  localparam logic [AW-1:0] A_ST_EVT  = 4'd0;
  localparam logic [AW-1:0] A_ST_LINK = 4'd1;
  localparam logic [AW-1:0] A_ST_GPIO = 4'd2;
  localparam logic [AW-1:0] A_EN_EVT  = 4'd3;
  localparam logic [AW-1:0] A_EN_LINK = 4'd4;
  localparam logic [AW-1:0] A_EN_GPIO = 4'd5;
  localparam logic [AW-1:0] A_ALM_EN  = 4'd6;
  localparam logic [AW-1:0] A_DIR     = 4'd7;
  localparam logic [AW-1:0] A_DOUT    = 4'd8;
  localparam logic [AW-1:0] A_POL     = 4'd9;
  localparam logic [AW-1:0] A_PIN     = 4'd10;

  localparam int ALM_BIT = 15;

  typedef struct packed {
    logic [DW-1:0] en_evt;
    logic [DW-1:0] en_link;
    logic [DW-1:0] en_gpio;
    logic [DW-1:0] alm_en;
    logic [DW-1:0] dir;
    logic [DW-1:0] dout;
    logic [DW-1:0] pol;
  } lah_ctrl_t;
endpackage

// File: rtl/lah_regs.sv
module lah_regs
  import lah_pkg::*;
#(
  parameter int N_INT  = 8,
  parameter int N_OPT  = 4,
  parameter int N_ALM  = 8,
  parameter int N_GPIO = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output lah_ctrl_t     ctrl
);
  localparam logic [DW-1:0] M_EVT  = DW'((32'd1 << N_INT) - 32'd1);
  localparam logic [DW-1:0] M_OPT  = DW'((32'd1 << N_OPT) - 32'd1);
  localparam logic [DW-1:0] M_LINK = M_OPT | (DW'(1) << ALM_BIT);
  localparam logic [DW-1:0] M_ALM  = DW'((32'd1 << N_ALM) - 32'd1);
  localparam logic [DW-1:0] M_GPIO = DW'((32'd1 << N_GPIO) - 32'd1);

  lah_ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    unique case (addr)
      A_EN_EVT:  ctrl_d.en_evt  = wdata & M_EVT;
      A_EN_LINK: ctrl_d.en_link = wdata & M_LINK;
      A_EN_GPIO: ctrl_d.en_gpio = wdata & M_GPIO;
      A_ALM_EN:  ctrl_d.alm_en  = wdata & M_ALM;
      A_DIR:     ctrl_d.dir     = wdata & M_GPIO;
      A_DOUT:    ctrl_d.dout    = wdata & M_GPIO;
      A_POL:     ctrl_d.pol     = wdata & M_GPIO;
      default:   ctrl_d = ctrl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/lah_gpio.sv
module lah_gpio #(
  parameter int N_GPIO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GPIO-1:0] pin_i,
  input  logic [N_GPIO-1:0] dir,
  input  logic [N_GPIO-1:0] dout,
  input  logic [N_GPIO-1:0] pol,
  output logic [N_GPIO-1:0] gpio_oe,
  output logic [N_GPIO-1:0] gpio_out,
  output logic [N_GPIO-1:0] pin_q,
  output logic [N_GPIO-1:0] hit
);
  logic [N_GPIO-1:0] pin_d;

  for (genvar i = 0; i < N_GPIO; i++) begin : g_pin
    always_comb begin
      hit[i]      = !dir[i] && (pin_i[i] == pol[i]);
      gpio_oe[i]  = dir[i];
      gpio_out[i] = dout[i];
      pin_d[i]    = pin_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
    end else begin
      pin_q <= pin_d;
    end
  end
endmodule

// File: rtl/lah_status.sv
module lah_status
  import lah_pkg::*;
#(
  parameter int N_INT  = 8,
  parameter int N_OPT  = 4,
  parameter int N_ALM  = 8,
  parameter int N_GPIO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INT-1:0]  evt_i,
  input  logic [N_OPT-1:0]  opt_i,
  input  logic [N_ALM-1:0]  alm_i,
  input  logic              mode_opt,
  input  logic [N_ALM-1:0]  alm_en,
  input  logic [N_GPIO-1:0] gpio_hit,
  input  logic              clr_evt,
  output logic [N_INT-1:0]  st_evt,
  output logic [DW-1:0]     st_link,
  output logic [N_GPIO-1:0] st_gpio
);
  logic [N_INT-1:0]  evt_d;
  logic [DW-1:0]     link_d;
  logic [N_GPIO-1:0] gpio_d;
  logic [N_ALM-1:0]  alm_gated;

  for (genvar j = 0; j < N_ALM; j++) begin : g_alm
    assign alm_gated[j] = alm_i[j] & alm_en[j] & mode_opt;
  end

  always_comb begin
    evt_d = (clr_evt ? '0 : st_evt) | evt_i;
    link_d = '0;
    link_d[N_OPT-1:0] = mode_opt ? opt_i : '0;
    link_d[ALM_BIT] = |alm_gated;
    gpio_d = gpio_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_evt  <= '0;
      st_link <= '0;
      st_gpio <= '0;
    end else begin
      st_evt  <= evt_d;
      st_link <= link_d;
      st_gpio <= gpio_d;
    end
  end
endmodule

// File: rtl/link_irq_hub.sv
module link_irq_hub
  import lah_pkg::*;
#(
  parameter int N_INT  = 8,
  parameter int N_OPT  = 4,
  parameter int N_ALM  = 8,
  parameter int N_GPIO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [3:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              mode_opt,
  input  logic [N_INT-1:0]  evt_i,
  input  logic [N_OPT-1:0]  opt_i,
  input  logic [N_ALM-1:0]  alm_i,
  input  logic [N_GPIO-1:0] gpio_in,
  output logic [N_GPIO-1:0] gpio_out,
  output logic [N_GPIO-1:0] gpio_oe,
  output logic              irq_o
);
  logic rs_meta, rst_n_s;
  lah_ctrl_t ctrl;
  logic [N_INT-1:0]  st_evt;
  logic [DW-1:0]     st_link;
  logic [N_GPIO-1:0] st_gpio;
  logic [N_GPIO-1:0] pin_q;
  logic [N_GPIO-1:0] gpio_hit;
  logic              clr_evt;
  logic [DW-1:0]     rd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_n_s <= rs_meta;
    end
  end

  lah_regs #(.N_INT(N_INT), .N_OPT(N_OPT), .N_ALM(N_ALM), .N_GPIO(N_GPIO)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .ctrl(ctrl)
  );

  lah_gpio #(.N_GPIO(N_GPIO)) u_gpio (
    .clk(clk), .rst_n(rst_n_s), .pin_i(gpio_in),
    .dir(ctrl.dir[N_GPIO-1:0]), .dout(ctrl.dout[N_GPIO-1:0]),
    .pol(ctrl.pol[N_GPIO-1:0]), .gpio_oe(gpio_oe), .gpio_out(gpio_out),
    .pin_q(pin_q), .hit(gpio_hit)
  );

  assign clr_evt = reg_re && (reg_addr == A_ST_EVT);

  lah_status #(.N_INT(N_INT), .N_OPT(N_OPT), .N_ALM(N_ALM), .N_GPIO(N_GPIO)) u_stat (
    .clk(clk), .rst_n(rst_n_s), .evt_i(evt_i), .opt_i(opt_i), .alm_i(alm_i),
    .mode_opt(mode_opt), .alm_en(ctrl.alm_en[N_ALM-1:0]), .gpio_hit(gpio_hit),
    .clr_evt(clr_evt), .st_evt(st_evt), .st_link(st_link), .st_gpio(st_gpio)
  );

  always_comb begin
    unique case (reg_addr)
      A_ST_EVT:  rd_d = DW'(st_evt);
      A_ST_LINK: rd_d = st_link;
      A_ST_GPIO: rd_d = DW'(st_gpio);
      A_EN_EVT:  rd_d = ctrl.en_evt;
      A_EN_LINK: rd_d = ctrl.en_link;
      A_EN_GPIO: rd_d = ctrl.en_gpio;
      A_ALM_EN:  rd_d = ctrl.alm_en;
      A_DIR:     rd_d = ctrl.dir;
      A_DOUT:    rd_d = ctrl.dout;
      A_POL:     rd_d = ctrl.pol;
      A_PIN:     rd_d = DW'(pin_q);
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      reg_rdata <= rd_d;
    end
  end

  assign irq_o = (|(st_evt & ctrl.en_evt[N_INT-1:0]))
               | (|(st_link & ctrl.en_link))
               | (|(st_gpio & ctrl.en_gpio[N_GPIO-1:0]));
endmodule

// File: rtl/lah_chk.sv
module lah_chk
  import lah_pkg::*;
#(
  parameter int N_INT  = 8,
  parameter int N_GPIO = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              reg_re,
  input logic [3:0]        reg_addr,
  input logic [15:0]       reg_wdata,
  input logic [15:0]       reg_rdata,
  input logic              mode_opt,
  input logic [N_GPIO-1:0] gpio_oe,
  input logic [N_GPIO-1:0] gpio_out,
  input logic              irq_o,
  input logic [N_INT-1:0]  st_evt,
  input logic [15:0]       st_link,
  input logic [N_GPIO-1:0] st_gpio
);
  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_DIR) |=> gpio_oe == $past(reg_wdata[N_GPIO-1:0])); // R7

  AST_OUT_FOLLOWS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_DOUT) |=> gpio_out == $past(reg_wdata[N_GPIO-1:0])); // R11

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_re && reg_addr == A_ST_EVT) |=> ((st_evt & $past(st_evt)) == $past(st_evt))); // R2

  AST_MODE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_opt |=> st_link == 16'h0); // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr > A_PIN) |=> reg_rdata == 16'h0); // R10

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_evt == '0 && st_link == '0 && st_gpio == '0) |-> !irq_o); // R9
endmodule

bind link_irq_hub lah_chk #(.N_INT(N_INT), .N_GPIO(N_GPIO)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .reg_we(reg_we), .reg_re(reg_re),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .mode_opt(mode_opt), .gpio_oe(gpio_oe), .gpio_out(gpio_out), .irq_o(irq_o),
  .st_evt(st_evt), .st_link(st_link), .st_gpio(st_gpio)
);

// File: tb/sim_link_irq_hub.sv
module sim_link_irq_hub;
  localparam int N_INT = 8, N_OPT = 4, N_ALM = 8, N_GPIO = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic mode_opt = 1'b0;
  logic [N_INT-1:0] evt_i = '0;
  logic [N_OPT-1:0] opt_i = '0;
  logic [N_ALM-1:0] alm_i = '0;
  logic [N_GPIO-1:0] gpio_in = '0;
  logic [N_GPIO-1:0] gpio_out, gpio_oe;
  logic irq_o;

  always #2 clk = ~clk;

  link_irq_hub #(.N_INT(N_INT), .N_OPT(N_OPT), .N_ALM(N_ALM), .N_GPIO(N_GPIO)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_opt(mode_opt),
    .evt_i(evt_i), .opt_i(opt_i), .alm_i(alm_i), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq_o(irq_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int rel_cnt = 0;
  int m_evt = 0, m_link = 0, m_gst = 0, m_pin = 0, m_rd = 0;
  int c_enevt = 0, c_enlink = 0, c_engp = 0, c_alm = 0, c_dir = 0, c_dout = 0, c_pol = 0;
  bit model_on = 0;

  function automatic int rd_of(int a);
    case (a)
      0: return m_evt;   1: return m_link;   2: return m_gst;
      3: return c_enevt; 4: return c_enlink; 5: return c_engp;
      6: return c_alm;   7: return c_dir;    8: return c_dout;
      9: return c_pol;   10: return m_pin;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int n_evt, n_link, n_gst, n_rd, w;
    model_on = 1;
    if (!rst_n) rel_cnt = 0;
    if (!rst_n || rel_cnt < 2) begin
      if (rst_n) rel_cnt++;
      m_evt = 0; m_link = 0; m_gst = 0; m_pin = 0; m_rd = 0;
      c_enevt = 0; c_enlink = 0; c_engp = 0; c_alm = 0; c_dir = 0; c_dout = 0; c_pol = 0;
    end else begin
      n_rd = reg_re ? rd_of(int'(reg_addr)) : m_rd;
      n_evt = ((reg_re && reg_addr == 0) ? 0 : m_evt) | int'(evt_i);
      n_link = 0;
      if (mode_opt) begin
        n_link = int'(opt_i);
        if ((int'(alm_i) & c_alm) != 0) n_link += 32768;
      end
      n_gst = 0;
      for (int i = 0; i < N_GPIO; i++)
        if (((c_dir >> i) & 1) == 0 && ((c_pol >> i) & 1) == int'(gpio_in[i]))
          n_gst |= (1 << i);
      m_pin = int'(gpio_in);
      m_evt = n_evt; m_link = n_link; m_gst = n_gst; m_rd = n_rd;
      if (reg_we) begin
        w = int'(reg_wdata);
        case (reg_addr)
          3: c_enevt = w & 'hFF;
          4: c_enlink = w & 'h800F;
          5: c_engp = w & 'hF;
          6: c_alm = w & 'hFF;
          7: c_dir = w & 'hF;
          8: c_dout = w & 'hF;
          9: c_pol = w & 'hF;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      chk("R9 irq", 32'(irq_o), 32'(((m_evt & c_enevt) | (m_link & c_enlink) | (m_gst & c_engp)) != 0));
      chk("R7 gpio_oe", 32'(gpio_oe), 32'(c_dir));
      chk("R7 gpio_out", 32'(gpio_out), 32'(c_dout));
      chk("R10 rdata", 32'(reg_rdata), 32'(m_rd));
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, string req, logic [15:0] exp);
    @(negedge clk); reg_re = 1; reg_addr = a;
    @(negedge clk); reg_re = 0;
    chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 irq in reset", 32'(irq_o), 0);
    chk("R1 oe in reset", 32'(gpio_oe), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 rdata after reset", 32'(reg_rdata), 0);
    rd(4'd0, "R1 event status after reset", 16'h0);

    // R2: latch and hold an event
    @(negedge clk); evt_i = 8'h08;
    @(negedge clk); evt_i = 8'h00;
    repeat (3) @(negedge clk);
    chk("R9 no irq while disabled", 32'(irq_o), 0);
    rd(4'd0, "R2 sticky event", 16'h0008);
    rd(4'd0, "R3 cleared by read", 16'h0000);

    // R9: enabled event drives interrupt, read clears it
    wr(4'd3, 16'h0008);
    rd(4'd3, "R11 enable read-back", 16'h0008);
    @(negedge clk); evt_i = 8'h08;
    @(negedge clk); evt_i = 8'h00;
    chk("R9 irq raised", 32'(irq_o), 1);
    rd(4'd0, "R9 read of source", 16'h0008);
    chk("R9 irq falls after clear", 32'(irq_o), 0);

    // R3: event held during the read survives
    @(negedge clk); evt_i = 8'h01;
    @(negedge clk); evt_i = 8'h02; reg_re = 1; reg_addr = 4'd0;
    @(negedge clk); reg_re = 0; evt_i = 8'h00;
    chk("R3 read returns prior events", 32'(reg_rdata), 32'h0001);
    rd(4'd0, "R3 simultaneous event kept", 16'h0002);

    // R4: optical pins gated by mode
    opt_i = 4'hF; mode_opt = 0;
    repeat (2) @(negedge clk);
    rd(4'd1, "R4 masked when mode off", 16'h0000);
    mode_opt = 1; opt_i = 4'h5;
    repeat (2) @(negedge clk);
    rd(4'd1, "R4 live in optical mode", 16'h0005);
    wr(4'd4, 16'h0004);
    chk("R9 link source irq", 32'(irq_o), 1);
    opt_i = 4'h0;
    repeat (2) @(negedge clk);
    chk("R9 link level irq drops", 32'(irq_o), 0);

    // R5: alarm summary
    alm_i = 8'h05; wr(4'd6, 16'h0004);
    @(negedge clk);
    rd(4'd1, "R5 matching alarm enable", 16'h8000);
    wr(4'd6, 16'h0002);
    @(negedge clk);
    rd(4'd1, "R5 non-matching alarm enable", 16'h0000);
    wr(4'd6, 16'h0001); mode_opt = 0;
    repeat (2) @(negedge clk);
    rd(4'd1, "R5 alarm masked by mode", 16'h0000);
    alm_i = 8'h00;

    // R7/R6/R8: general-purpose pins
    wr(4'd7, 16'h0003);
    wr(4'd8, 16'h0002);
    chk("R7 oe", 32'(gpio_oe), 32'h3);
    chk("R7 out", 32'(gpio_out), 32'h2);
    wr(4'd9, 16'h0004);
    gpio_in = 4'b0100;
    repeat (2) @(negedge clk);
    rd(4'd2, "R6 level match high and low", 16'h000C);
    wr(4'd5, 16'h0008);
    chk("R9 pin trigger irq", 32'(irq_o), 1);
    gpio_in = 4'b1011;
    repeat (2) @(negedge clk);
    rd(4'd2, "R6 opposing levels and outputs", 16'h0000);
    chk("R9 pin irq drops", 32'(irq_o), 0);
    rd(4'd10, "R8 pin levels", 16'h000B);

    // R10: read-only writes ignored, unmapped reads zero
    @(negedge clk); evt_i = 8'h10;
    @(negedge clk); evt_i = 8'h00;
    wr(4'd0, 16'hFFFF);
    wr(4'd10, 16'hFFFF);
    rd(4'd0, "R10 write to status ignored", 16'h0010);
    rd(4'd10, "R10 write to pin level ignored", 16'h000B);
    rd(4'd13, "R10 unmapped read", 16'h0000);
    wr(4'd7, 16'h0000);
    chk("R11 direction change next cycle", 32'(gpio_oe), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule